// File: doc/BRIEF.md
# Sequential Booth Radix-2 Signed Multiplier

This block multiplies two signed two's-complement operands of `N` bits (16 by default) and gives their full signed product of `2N` bits. It does this over several clock cycles and uses little logic. It latches both operands on a start request. It then spends one cycle on each bit of the multiplier, starting at the least significant bit. In each cycle it looks at that bit and at the bit below it. From those two bits it decides to add the multiplicand to a running partial product, subtract it, or leave the partial product as it is. The partial product, the remaining multiplier bits and the saved lower bit then move one place to the right as a single arithmetic shift.

A run of ones in the multiplier therefore costs one subtraction where the run begins and one addition just past its end. A plain shift-and-add scheme would need one addition for every one bit. Software or a sequencer pulses `start` while the block is idle. `busy` stays high for the `N` working cycles. `done` then pulses for one cycle, and `product` holds the result until the next accepted start.

Top module: `booth_seq_mult`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `busy`=0, `done`=0 and `product`=0.
- R2: A `start` sampled high while `busy` is low captures `mcand_i` and `mplier_i` and raises `busy` in the next cycle. Later changes to the operand inputs have no effect on that result.
- R3: A `start` sampled while `busy` is high is ignored. It changes neither the result nor the timing.
- R4: Exactly `N` working cycles follow an accepted start. If start is sampled at edge k, `busy` falls and `done` rises after edge k+N.
- R5: `done` stays high for exactly one cycle. `product` keeps its value from that cycle until the next accepted start.
- R6: The recoding decides from each pair (current multiplier bit, bit below it). 1/0 subtracts the multiplicand, 0/1 adds it, and 0/0 and 1/1 leave the partial product unchanged. The bit below the least significant bit is taken as 0. Alternating and all-ones multipliers still give the exact product.
- R7: With `done` high, `product` equals the signed product of the captured operands as a `2N`-bit two's-complement value. For example, 2 × 6 gives 12.
- R8: The most negative value times itself gives the positive product 2^(2N-2). The most negative value times 1 or times the largest positive value also gives the exact result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a multiplication; honoured only while idle |
| mcand_i | input | N | Multiplicand, signed |
| mplier_i | input | N | Multiplier, signed |
| busy | output | 1 | High during the N working cycles |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2N | Signed product, held after done |

## Verification
Several kinds of multiplier are applied:
- Alternating 0101… and 1010… patterns make every cycle an add or a subtract, which exposes a swapped add/subtract choice or a wrong previous bit.
- All-ones and all-zeros multipliers check that runs of ones give only one subtract and that the skip pairs truly skip.
- Pairings that include the most negative value need the extra accumulator bit and show whether the shift carries the sign correctly.
- The 2 × 6 case and a set of random operand pairs check general arithmetic.

Further cases change the operand inputs, or pulse `start`, while a multiplication is in progress. These show whether the operands are captured and whether the block ignores requests that arrive while it is busy.

// File: rtl/booth_pkg.sv
// Shared types for the sequential Booth multiplier.
// Assumes: nothing beyond a 1800-2017 compiler.
package booth_pkg;
    // Action chosen for one iteration from the scanned bit pair
    typedef enum logic [1:0] {
        STEP_SKIP = 2'd0,
        STEP_ADD  = 2'd1,
        STEP_SUB  = 2'd2
    } step_e;
endpackage

// File: rtl/booth_recoder.sv
// Radix-2 Booth recoder: maps (current bit, bit below) to an action.
// Assumes: prev_bit is 0 for the first iteration (the caller clears it).
module booth_recoder
    import booth_pkg::*;
(
    input  logic  cur_bit,
    input  logic  prev_bit,
    output step_e step
);
    // Decode the pair: entering a run of ones subtracts, leaving it adds
    always_comb begin
        case ({cur_bit, prev_bit})
            2'b10:   step = STEP_SUB;
            2'b01:   step = STEP_ADD;
            default: step = STEP_SKIP;
        endcase
    end
endmodule

// File: rtl/booth_addsub.sv
// Accumulator adder/subtractor of width W.
// Assumes: addend is already sign-extended to W bits; W has one guard bit
// so that subtracting the most negative operand cannot overflow.
module booth_addsub
    import booth_pkg::*;
#(
    parameter int W = 17
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] addend,
    input  step_e        step,
    output logic [W-1:0] sum
);
    // Select add, subtract or pass-through for this iteration
    always_comb begin
        case (step)
            STEP_ADD: sum = acc + addend;
            STEP_SUB: sum = acc - addend;
            default:  sum = acc;
        endcase
    end
endmodule

// File: rtl/booth_ctrl.sv
// Iteration sequencer: accepts start while idle, counts N working cycles,
// then pulses done for one cycle.
// Assumes: synchronous active-low reset; N >= 2.
module booth_ctrl #(
    parameter int N = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic load,
    output logic step_en
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] iter_q;
    logic          last_iter;

    assign load      = start && !busy;
    assign step_en   = busy;
    assign last_iter = (iter_q == CW'(N - 1));

    // Busy/done flags and iteration counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            iter_q <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                busy   <= 1'b1;
                iter_q <= '0;
            end else if (busy) begin
                iter_q <= iter_q + 1'b1;
                if (last_iter) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R4
    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R2
endmodule

// File: rtl/booth_seq_mult.sv
// Sequential radix-2 Booth signed multiplier, N x N -> 2N bits.
// Holds an N+1 bit accumulator, the shifting multiplier and the saved
// lower bit; each busy cycle performs one recode, add/sub and an
// arithmetic right shift of {acc, mq, prev} as one unit.
// Assumes: operands are two's complement; start is ignored while busy.
module booth_seq_mult
    import booth_pkg::*;
#(
    parameter int N = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N-1:0]   mcand_i,
    input  logic [N-1:0]   mplier_i,
    output logic           busy,
    output logic           done,
    output logic [2*N-1:0] product
);
    localparam int W = N + 1;

    logic [N-1:0] mcand_q;
    logic [W-1:0] acc_q;
    logic [N-1:0] mq_q;
    logic         prev_q;
    logic         load;
    logic         step_en;
    step_e        step;
    logic [W-1:0] addend;
    logic [W-1:0] sum;

    booth_ctrl #(.N(N)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .busy    (busy),
        .done    (done),
        .load    (load),
        .step_en (step_en)
    );

    booth_recoder rec_i (
        .cur_bit  (mq_q[0]),
        .prev_bit (prev_q),
        .step     (step)
    );

    assign addend = {mcand_q[N-1], mcand_q};

    booth_addsub #(.W(W)) alu_i (
        .acc    (acc_q),
        .addend (addend),
        .step   (step),
        .sum    (sum)
    );

    // Capture operands on load; add/sub then shift right on each step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            acc_q   <= '0;
            mq_q    <= '0;
            prev_q  <= 1'b0;
        end else if (load) begin
            mcand_q <= mcand_i;
            acc_q   <= '0;
            mq_q    <= mplier_i;
            prev_q  <= 1'b0;
        end else if (step_en) begin
            acc_q   <= {sum[W-1], sum[W-1:1]};
            mq_q    <= {sum[0], mq_q[N-1:1]};
            prev_q  <= mq_q[0];
        end
    end

    assign product = {acc_q[N-1:0], mq_q};

    AST_OPERAND_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mcand_q)); // R3
    AST_PRODUCT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product)); // R5
    AST_DONE_AFTER_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy)); // R4
endmodule

// File: tb/booth_seq_mult_tb_top.sv
// Scoreboard bench: run_op pushes the expected product, the monitor pops
// and compares it when done pulses, and also checks latency and hold.
module booth_seq_mult_tb_top;
    localparam int N = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N-1:0]   mcand_i = '0;
    logic [N-1:0]   mplier_i = '0;
    logic           busy;
    logic           done;
    logic [2*N-1:0] product;

    int total = 0;
    int bad   = 0;
    int pcnt  = 0;

    logic [2*N-1:0] exp_q[$];
    string          tag_q[$];
    int             t_q[$];

    logic [2*N-1:0] hold_val;
    bit             hold_chk = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    booth_seq_mult #(.N(N)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mcand_i  (mcand_i),
        .mplier_i (mplier_i),
        .busy     (busy),
        .done     (done),
        .product  (product)
    );

    always @(posedge clk) pcnt <= pcnt + 1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [2*N-1:0] ref_mul(input logic [N-1:0] a,
                                               input logic [N-1:0] b);
        logic signed [2*N-1:0] sa;
        logic signed [2*N-1:0] sb;
        sa = $signed({{N{a[N-1]}}, a});
        sb = $signed({{N{b[N-1]}}, b});
        return sa * sb;
    endfunction

    // Monitor: compare on done, check latency and the hold after done
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_chk) begin
                chk(!done, "R5 done width", 64'(done), 64'd0);
                chk(product == hold_val, "R5 product hold", 64'(product), 64'(hold_val));
                hold_chk = 1'b0;
            end
            if (done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected done", 64'd1, 64'd0);
                end else begin
                    logic [2*N-1:0] e;
                    string          tg;
                    int             t0;
                    e  = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    t0 = t_q.pop_front();
                    chk(product == e, tg, 64'(product), 64'(e));
                    chk((pcnt - t0) == N + 1, "R4 latency", 64'(pcnt - t0), 64'(N + 1));
                    hold_val = product;
                    hold_chk = 1'b1;
                end
            end
        end
    end

    // Driver: issue one operation and wait for its result
    task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b,
                          input string tag, input bit poke);
        while (busy) @(negedge clk);
        mcand_i = a;
        mplier_i = b;
        start = 1'b1;
        exp_q.push_back(ref_mul(a, b));
        tag_q.push_back(tag);
        t_q.push_back(pcnt);
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R2 busy after start", 64'(busy), 64'd1);
        // R2: disturb operand inputs after capture
        mcand_i = ~a;
        mplier_i = b ^ 16'h5A3C;
        if (poke) begin
            // R3: request while busy must be ignored
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy, "R1 busy", 64'(busy), 64'd0);
        chk(!done, "R1 done", 64'(done), 64'd0);
        chk(product == '0, "R1 product", 64'(product), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(16'd2, 16'd6, "R7 2x6", 1'b0);
        chk(product == 32'd12, "R7 2x6 is 12", 64'(product), 64'd12);
        run_op(16'h1234, 16'h5555, "R6 alternating 0101", 1'b0);
        run_op(16'hF00D, 16'hAAAA, "R6 alternating 1010", 1'b0);
        run_op(16'h1234, 16'hFFFF, "R6 all ones", 1'b0);
        run_op(16'h7ABC, 16'h0000, "R6 all zeros", 1'b0);
        run_op(16'h8001, 16'h7FFF, "R6 long run", 1'b0);
        run_op(16'h8000, 16'h8000, "R8 min x min", 1'b0);
        chk(product == 32'h4000_0000, "R8 min x min value", 64'(product), 64'h4000_0000);
        run_op(16'h8000, 16'h0001, "R8 min x 1", 1'b0);
        run_op(16'h8000, 16'h7FFF, "R8 min x max", 1'b0);
        run_op(16'h7FFF, 16'h8000, "R8 max x min", 1'b0);
        run_op(16'h7FFF, 16'h7FFF, "R7 max x max", 1'b0);
        run_op(16'hFFFF, 16'hFFFF, "R7 -1 x -1", 1'b0);
        run_op(16'h0123, 16'hFEDC, "R3 start while busy", 1'b1);
        run_op(16'hC001, 16'h3FFE, "R3 start while busy 2", 1'b1);
        for (int i = 0; i < 40; i++) begin
            run_op(N'($urandom()), N'($urandom()), "R7 random", (i % 5) == 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule